// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. Its pins are split into banks of equal width (three banks of 32 pins by default; the pin index is bank × 32 + bit). For each pin, software can choose between input and output and can set the output level. An input can also be inverted, and it can report rising and falling edges as sticky pending bits. All pending bits from every bank drive one shared interrupt line.

Registers are reached over a simple single-cycle word bus. The word address has two fields. The upper four bits select the register group and the lower two bits select the bank, so a register's byte address is group × 0x10 + bank × 0x4. Output levels can only be changed through write-one set and write-one clear groups, so two agents never need a read-modify-write to change different pins. Inputs pass through a two-flop synchronizer before they are used.

Read responses come from a two-state response machine. In ST_IDLE it has no response pending. A read request takes it to ST_RESP (transition IDLE→RESP), where the read word is presented with a valid strobe for one cycle. Another read in ST_RESP keeps it there (RESP→RESP). A cycle with no read takes it back to idle (RESP→IDLE). With no read, it stays in ST_IDLE (IDLE→IDLE).

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset, all pins are inputs, `pin_oe` and `pin_out` are all zero, `irq` is low, and every register reads 0.
- R2: Group 0 (direction) holds one bit per pin: 1 drives `pin_oe` high (output) and 0 leaves the pin an input. The new value appears on `pin_oe` in the cycle after the write.
- R3: Group 3 (set) sets the output data bits written as 1, and group 4 (clear) clears them. Zero bits leave the pins unchanged, and `pin_out` follows in the cycle after the write.
- R4: Word address bits [5:2] select the group (direction 0, invert 1, level 2, set 3, clear 4, rise enable 5, fall enable 6, pending 9) and bits [1:0] select the bank. A bank's word affects only that bank's 32 pins.
- R5: A read of group 2 (level) returns, for output pins, the output data bit. For input pins it returns the synchronized input XOR the group 1 (invert) bit. A change on an input reaches this value after two clock edges.
- R6: A pin's pending bit (group 9) is set by a rising edge of its inverted-and-synchronized input when its group 5 bit is 1. It is set by a falling edge when its group 6 bit is 1, and by either edge when both bits are 1. With neither bit set, no edge sets it.
- R7: Pending bits stay set until software writes 1 to them. Writing 1 to a pending bit clears only that bit, and a 0 leaves it unchanged.
- R8: When a new edge and a write-one clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly while at least one pending bit in any bank is set.
- R10: Reads of groups 7, 8 and 10–15, of the set and clear groups, and of bank slot 3 return 0. Writes to them change no register and no pin.
- R11: A read request (`bus_sel` high, `bus_we` low) sampled at a clock edge gives `bus_rvalid` high with the read word on `bus_rdata` for the next cycle. With no request, `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 6 | Word address: [5:2] group, [1:0] bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| pin_in | input | 96 | Raw pin inputs, asynchronous |
| pin_out | output | 96 | Output data per pin |
| pin_oe | output | 96 | Output enable per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench checks the edge-wins race by timing a clear of a pending bit into the same cycle as a new edge on that bit. A design where the clear wins would lose that interrupt and read back 0. It reads the level of a bank where output and input pins are mixed, both before and after inversion. A design that shows the output register for input pins, or ignores inversion, returns the wrong bits. It writes to and reads from bank slot 3 and the write-only groups; a decoder that aliases addresses would disturb a real bank or return nonzero data. It also checks that a partial write-one clear keeps the other pending bits, and that an interrupt from the last bank raises `irq` on its own.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [3:0] {
        GRP_DIR     = 4'd0,
        GRP_INV     = 4'd1,
        GRP_LEVEL   = 4'd2,
        GRP_OSET    = 4'd3,
        GRP_OCLR    = 4'd4,
        GRP_RISE_EN = 4'd5,
        GRP_FALL_EN = 4'd6,
        GRP_RSV7    = 4'd7,
        GRP_RSV8    = 4'd8,
        GRP_PEND    = 4'd9,
        GRP_RSV10   = 4'd10
    } grp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       grp,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] rd_word,
    output logic             pend_any
);
    logic [WIDTH-1:0] dir_q, inv_q, dout_q, rise_q, fall_q, pend_q, prev_q;
    logic [WIDTH-1:0] sync_in, adj_in, hit, clr_mask, level;
    logic wr_dir, wr_inv, wr_set, wr_clr, wr_rise, wr_fall, wr_pend;

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_in)
    );

    assign adj_in = sync_in ^ inv_q;
    assign hit    = (adj_in & ~prev_q & rise_q) | (~adj_in & prev_q & fall_q);

    assign wr_dir  = wr_en && (grp == GRP_DIR);
    assign wr_inv  = wr_en && (grp == GRP_INV);
    assign wr_set  = wr_en && (grp == GRP_OSET);
    assign wr_clr  = wr_en && (grp == GRP_OCLR);
    assign wr_rise = wr_en && (grp == GRP_RISE_EN);
    assign wr_fall = wr_en && (grp == GRP_FALL_EN);
    assign wr_pend = wr_en && (grp == GRP_PEND);

    assign clr_mask = wr_pend ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            inv_q  <= '0;
            dout_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
            pend_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= adj_in;
            if (wr_dir)  dir_q  <= wdata;
            if (wr_inv)  inv_q  <= wdata;
            if (wr_rise) rise_q <= wdata;
            if (wr_fall) fall_q <= wdata;
            if (wr_set)
                dout_q <= dout_q | wdata;
            else if (wr_clr)
                dout_q <= dout_q & ~wdata;
            pend_q <= (pend_q & ~clr_mask) | hit;
        end
    end

    assign level = (dir_q & dout_q) | (~dir_q & adj_in);

    always_comb begin
        case (grp)
            GRP_DIR:     rd_word = dir_q;
            GRP_INV:     rd_word = inv_q;
            GRP_LEVEL:   rd_word = level;
            GRP_RISE_EN: rd_word = rise_q;
            GRP_FALL_EN: rd_word = fall_q;
            GRP_PEND:    rd_word = pend_q;
            default:     rd_word = '0;
        endcase
    end

    assign pin_out  = dout_q;
    assign pin_oe   = dir_q;
    assign pend_any = |pend_q;

    AST_SET_BITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_out & $past(wdata)) == $past(wdata))); // R3

    AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_out & $past(wdata)) == '0)); // R3

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe)); // R2

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit))); // R8

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_mask)) == '0)); // R7
endmodule

// File: rtl/gpio_rsp_fsm.sv
module gpio_rsp_fsm
    import gpio_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_req) rdata <= rd_word;
        else             rdata <= '0;
    end

    assign rvalid = (state_q == ST_RESP);
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [5:0]                  bus_waddr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    output logic                        irq
);
    localparam int BANK_SEL_W = 2;
    localparam int GRP_W      = 4;

    logic [GRP_W-1:0]      grp;
    logic [BANK_SEL_W-1:0] bank_idx;
    logic                  rd_req;
    logic [BANK_W-1:0]     rd_words [NUM_BANKS];
    logic [NUM_BANKS-1:0]  pend_vec;
    logic [BANK_W-1:0]     rd_sel;

    assign grp      = bus_waddr[BANK_SEL_W +: GRP_W];
    assign bank_idx = bus_waddr[BANK_SEL_W-1:0];
    assign rd_req   = bus_sel && !bus_we;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_sel && bus_we && (bank_idx == BANK_SEL_W'(b));

        gpio_bank #(.WIDTH(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .grp      (grp),
            .wdata    (bus_wdata),
            .pin_in   (pin_in[b*BANK_W +: BANK_W]),
            .pin_out  (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe   (pin_oe[b*BANK_W +: BANK_W]),
            .rd_word  (rd_words[b]),
            .pend_any (pend_vec[b])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_SEL_W'(b)) rd_sel = rd_words[b];
        end
    end

    gpio_rsp_fsm #(.DATA_W(BANK_W)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_word (rd_sel),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata)
    );

    assign irq = |pend_vec;

    AST_RVALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid); // R11

    AST_RVALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid); // R11

    AST_UNMAPPED_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (int'(bank_idx) >= NUM_BANKS)) |=> (bus_rdata == '0)); // R10

    AST_WRITE_ONLY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (grp == GRP_OSET || grp == GRP_OCLR)) |=> (bus_rdata == '0)); // R10
endmodule

// File: tb/gpio_banked_ctrl_tb.sv
module gpio_banked_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_out;
    logic [95:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    gpio_banked_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [5:0] wa(int g, int b);
        return 6'((g << 2) | b);
    endfunction

    task automatic check(string req, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(int g, int b, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = wa(g, b); bus_wdata = d;
    endtask

    task automatic bus_read(int g, int b, logic [31:0] e, string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_waddr = wa(g, b); bus_wdata = '0;
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    task automatic bus_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_we = 1'b0;
        end
    endtask

    // Monitor: pops expected read words as responses appear
    always @(posedge clk) begin
        #1;
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 actual unexpected rvalid expected none");
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {64'b0, bus_rdata}, {64'b0, e});
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pin_out", pin_out, '0);
        check("R1 irq", {95'b0, irq}, '0);
        bus_read(0, 0, 32'h0, "R1 dir reg");
        bus_read(9, 2, 32'h0, "R1 pend reg");
        bus_idle(1);

        // R2 / R4: direction on bank 1 only
        bus_write(0, 1, 32'h0000_FFFF);
        bus_idle(1);
        check("R2 R4 pin_oe", pin_oe, {32'h0, 32'h0000_FFFF, 32'h0});
        bus_read(0, 1, 32'h0000_FFFF, "R2 dir readback");
        bus_idle(1);

        // R3: set / clear
        bus_write(3, 1, 32'h0000_0F0F);
        bus_idle(1);
        check("R3 set", pin_out, {32'h0, 32'h0000_0F0F, 32'h0});
        bus_write(3, 1, 32'hF000_0000);
        bus_idle(1);
        check("R3 set keeps", pin_out, {32'h0, 32'hF000_0F0F, 32'h0});
        bus_write(4, 1, 32'h0000_000F);
        bus_idle(1);
        check("R3 clear", pin_out, {32'h0, 32'hF000_0F00, 32'h0});

        // R5: level of mixed bank
        bus_read(2, 1, 32'h0000_0F00, "R5 mixed level");
        bus_idle(1);

        // R5: inputs on bank 2, then inverted
        pin_in[95:64] = 32'hA5A5_0000;
        bus_idle(3);
        bus_read(2, 2, 32'hA5A5_0000, "R5 input level");
        bus_write(1, 2, 32'hFFFF_FFFF);
        bus_read(2, 2, 32'h5A5A_FFFF, "R5 inverted level");
        bus_write(1, 2, 32'h0);
        bus_idle(2);
        check("R6 no enable no irq", {95'b0, irq}, '0);

        // R6: edge enables on bank 0
        bus_write(5, 0, 32'h5);
        bus_write(6, 0, 32'h6);
        bus_idle(1);
        pin_in[3:0] = 4'hF;
        bus_idle(4);
        check("R9 irq high", {95'b0, irq}, 96'd1);
        bus_read(9, 0, 32'h5, "R6 rising");
        bus_idle(1);
        pin_in[3:0] = 4'h0;
        bus_idle(4);
        bus_read(9, 0, 32'h7, "R6 falling and both");
        // R7: partial clear
        bus_write(9, 0, 32'h2);
        bus_read(9, 0, 32'h5, "R7 partial w1c");
        bus_write(9, 0, 32'h5);
        bus_idle(1);
        check("R9 irq low", {95'b0, irq}, '0);
        bus_read(9, 0, 32'h0, "R7 all cleared");
        bus_idle(1);

        // R8: edge and clear in same cycle
        pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = wa(9, 0); bus_wdata = 32'h1;
        bus_idle(1);
        bus_read(9, 0, 32'h1, "R8 edge wins");
        bus_write(9, 0, 32'h1);
        bus_idle(1);

        // R10: unmapped reads and writes
        bus_read(7, 0, 32'h0, "R10 group7");
        bus_read(0, 3, 32'h0, "R10 bank slot3");
        bus_read(3, 1, 32'h0, "R10 set read");
        bus_read(10, 0, 32'h0, "R10 group10");
        bus_write(0, 3, 32'hFFFF_FFFF);
        bus_write(3, 3, 32'hFFFF_FFFF);
        bus_write(8, 0, 32'hFFFF_FFFF);
        bus_idle(1);
        check("R10 pin_oe untouched", pin_oe, {32'h0, 32'h0000_FFFF, 32'h0});
        check("R10 pin_out untouched", pin_out, {32'h0, 32'hF000_0F00, 32'h0});
        bus_read(0, 0, 32'h0, "R10 dir b0");
        bus_read(0, 1, 32'h0000_FFFF, "R10 dir b1");
        bus_read(0, 2, 32'h0, "R10 dir b2");
        bus_idle(1);

        // R9 / R4: last bank alone raises irq
        bus_write(6, 2, 32'h8000_0000);
        bus_idle(1);
        pin_in[95] = 1'b0;
        bus_idle(4);
        check("R9 bank2 irq", {95'b0, irq}, 96'd1);
        bus_read(9, 2, 32'h8000_0000, "R4 bank2 pend");
        bus_read(9, 0, 32'h0, "R4 bank0 pend");
        bus_write(9, 2, 32'h8000_0000);
        bus_idle(1);
        check("R9 irq cleared", {95'b0, irq}, '0);

        // R11: back-to-back reads then idle
        bus_read(5, 0, 32'h5, "R11 b2b first");
        bus_read(6, 0, 32'h6, "R11 b2b second");
        bus_idle(3);
        check("R11 rvalid idle", {95'b0, bus_rvalid}, '0);
        check("R11 all responses", 96'(exp_q.size()), '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule